// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block gives a host access to a small byte-wide register file over a half-duplex serial bus made of an enable line, a serial clock and one shared data line. Every frame is sixteen bits long: a direction flag, a seven-bit register address and eight data bits, each field sent most significant bit first. A write frame stores its data byte into the addressed register. A read frame makes the slave take over the shared line after the address and return the register contents to the host.

All three bus inputs are brought into the system clock domain through two-flop synchronizers and are handled by edge detection on the synchronized copies. A bit in the control register selects an optional three-sample majority filter on those inputs. The filter suppresses single-sample glitches at the cost of a lower usable serial clock rate. Three identification registers are fixed, a device-select byte and the configuration registers are writable, and every other address reads as zero. Each completed write frame also produces a one-cycle strobe that carries the address and data it delivered.

The shared line is modelled as a data input, a data output and an output enable. A pad cell outside the block combines them.

Top module: `ser3w_slave`

## Requirements
- R1: A frame is a direction flag (1 = read, 0 = write), then address bits A6..A0, then data bits D7..D0. The flag, the address and the write data are sampled on rising serial clock edges. A complete write frame to a writable address stores the data byte there.
- R2: In a read frame the output enable stays low through the flag and the seven address bits. Read data is launched on falling serial clock edges: D7 on the falling edge after A0, then one bit per falling edge down to D0. The host samples each bit on the next rising edge.
- R3: Addresses 00h, 01h and 02h always read 28h, E0h and 00h. Writes to them change nothing.
- R4: After reset, register 10h reads 46h. Registers 11h, 14h and 17h read FFh. Registers 12h, 13h, 15h, 16h, 18h and 19h read 7Fh. Registers 1Ah, 1Bh, 1Ch and 1Eh read 00h.
- R5: Register 03h is read/write and resets to 43h.
- R6: Addresses 04h..0Fh, 1Dh and 20h..7Fh read 00h, and writes to them are discarded.
- R7: If the enable falls before all sixteen bits have arrived, the frame is dropped: there is no strobe and no register update.
- R8: Each complete write frame produces exactly one single-cycle write strobe, whatever the address. The strobe carries the frame's address and data.
- R9: The output enable is low after reset. It goes low within one system cycle of the synchronized enable falling. In a read frame, D0 stays on the line until the enable falls.
- R10: Bit 6 of register 10h turns on the input majority filter, and this bit is set after reset. With the filter on, a serial clock pulse lasting one system cycle is ignored. With the filter off, the same pulse counts as a rising edge and samples one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Frame enable, high during a frame |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Shared data line as seen at the pad |
| ser_dout | output | 1 | Read data bit toward the pad |
| ser_doe | output | 1 | Pad drive enable for read data |
| wr_stb | output | 1 | One-cycle strobe per completed write frame |
| wr_addr | output | 7 | Address carried by the strobe |
| wr_data | output | 8 | Data carried by the strobe |

## Verification
The bench checks the turnaround in read frames. A slave that drives the line during the address would collide with the host, and one that launches data on rising edges would be one bit early. It also checks that D0 is still on the line after the last falling clock edge and that the line is released once the enable drops. Short frames are cut off after twelve bits: a slave that commits on the enable edge instead of on the sixteenth bit would corrupt a register. Writes to fixed, reserved and out-of-range addresses must read back unchanged. The filter is tested by injecting a one-cycle serial clock pulse into a write frame. With the filter on, the byte must arrive intact. With the filter off, the extra edge must shift in one bit, so the stored byte comes out rotated in a way that can be predicted.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int NREG       = 32;
    localparam int REG_AW     = $clog2(NREG);
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CTRL_IDX   = 16;
    localparam int FILT_BIT   = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Addresses that hold storage and accept writes.
    function automatic logic is_writable(input addr_t a);
        return (a == ADDR_W'(8'h03)) ||
               ((a >= ADDR_W'(8'h10)) && (a <= ADDR_W'(8'h1C))) ||
               (a == ADDR_W'(8'h1E));
    endfunction

    // Fixed identification values returned for the first three addresses.
    function automatic byte_t id_value(input addr_t a);
        case (a)
            ADDR_W'(0): return 8'h28;
            ADDR_W'(1): return 8'hE0;
            default:    return 8'h00;
        endcase
    endfunction

    // Value loaded into each storage slot by reset.
    function automatic byte_t reset_value(input int unsigned idx);
        case (idx)
            3:            return 8'h43;
            16:           return 8'h46;
            17, 20, 23:   return 8'hFF;
            18, 19, 21,
            22, 24, 25:   return 8'h7F;
            default:      return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ser3w_infilt.sv
module ser3w_infilt #(
    parameter int N_SIG       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] raw,
    input  logic             filt_en,
    output logic [N_SIG-1:0] clean
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_SIG-1:0] sync;
        logic [1:0][N_SIG-1:0]             hist;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw};
        st_d.hist = {st_q.hist[0], st_q.sync[SYNC_STAGES-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_SIG; i++) begin : g_bit
        logic a, b, c;
        assign a = st_q.sync[SYNC_STAGES-1][i];
        assign b = st_q.hist[0][i];
        assign c = st_q.hist[1][i];
        assign clean[i] = filt_en ? ((a & b) | (a & c) | (b & c)) : a;
    end

endmodule

// File: rtl/ser3w_frame.sv
module ser3w_frame
    import ser3w_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  sck,
    input  logic  sdi,
    input  byte_t rd_data,
    output addr_t rd_addr,
    output logic  sdo,
    output logic  sdo_oe,
    output logic  wr_stb,
    output addr_t wr_addr,
    output byte_t wr_data
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic             en_prev;
        logic             sck_prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             rw;
        addr_t            addr;
        byte_t            wdat;
        byte_t            osh;
        logic             load;
        logic             oe;
        logic             obit;
        logic             stb;
        addr_t            sa;
        byte_t            sd;
    } frm_t;

    frm_t st_d, st_q;
    logic en_rise, en_fall, sck_rise, sck_fall;

    assign en_rise  = en & ~st_q.en_prev;
    assign en_fall  = ~en & st_q.en_prev;
    assign sck_rise = sck & ~st_q.sck_prev;
    assign sck_fall = ~sck & st_q.sck_prev;

    always_comb begin
        st_d          = st_q;
        st_d.stb      = 1'b0;
        st_d.en_prev  = en;
        st_d.sck_prev = sck;
        if (st_q.load) begin
            st_d.osh  = rd_data;
            st_d.load = 1'b0;
        end
        if (en_fall) begin
            st_d.active = 1'b0;
            st_d.oe     = 1'b0;
            st_d.load   = 1'b0;
        end else if (en_rise) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.rw     = 1'b0;
            st_d.oe     = 1'b0;
        end else if (st_q.active) begin
            if (sck_rise && (st_q.cnt < C_FULL)) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == '0) begin
                    st_d.rw = sdi;
                end else if (st_q.cnt <= C_HDR) begin
                    st_d.addr = {st_q.addr[ADDR_W-2:0], sdi};
                    if ((st_q.cnt == C_HDR) && st_q.rw) st_d.load = 1'b1;
                end else begin
                    st_d.wdat = {st_q.wdat[DATA_W-2:0], sdi};
                    if ((st_q.cnt == C_LAST) && !st_q.rw) begin
                        st_d.stb = 1'b1;
                        st_d.sa  = st_q.addr;
                        st_d.sd  = {st_q.wdat[DATA_W-2:0], sdi};
                    end
                end
            end else if (sck_fall && st_q.rw && (st_q.cnt > C_HDR) && (st_q.cnt < C_FULL)) begin
                st_d.oe   = 1'b1;
                st_d.obit = st_q.osh[DATA_W-1];
                st_d.osh  = {st_q.osh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.addr;
    assign sdo     = st_q.obit;
    assign sdo_oe  = st_q.oe;
    assign wr_stb  = st_q.stb;
    assign wr_addr = st_q.sa;
    assign wr_data = st_q.sd;

    // R9: the line is released right after the enable falls
    a_r9_release_on_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !st_q.oe);

    // R2: only a read frame ever turns the driver on
    a_r2_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> st_q.rw);

    // R2: a driven bit changes only after a falling serial clock edge
    a_r2_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oe && !$stable(st_q.obit)) |-> $past(sck_fall));

    // R8: the write strobe lasts one cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |=> !st_q.stb);

endmodule

// File: rtl/ser3w_regs.sv
module ser3w_regs
    import ser3w_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  addr_t waddr,
    input  byte_t wdata,
    input  addr_t raddr,
    output byte_t rdata,
    output logic  filt_en
);

    byte_t mem_d [NREG];
    byte_t mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we && is_writable(waddr)) mem_d[waddr[REG_AW-1:0]] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= reset_value(i);
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        if (raddr < ADDR_W'(3))      rdata = id_value(raddr);
        else if (is_writable(raddr)) rdata = mem_q[raddr[REG_AW-1:0]];
        else                         rdata = '0;
    end

    assign filt_en = mem_q[CTRL_IDX][FILT_BIT];

    // R1: a write to a writable address is visible on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_writable(waddr)) |=> (mem_q[$past(waddr[REG_AW-1:0])] == $past(wdata)));

endmodule

// File: rtl/ser3w_slave.sv
module ser3w_slave
    import ser3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [2:0] clean;
    logic       filt_en;
    addr_t      rd_addr;
    byte_t      rd_data;

    ser3w_infilt #(.N_SIG(3), .SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     ({ser_din, ser_clk, ser_en}),
        .filt_en (filt_en),
        .clean   (clean)
    );

    ser3w_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clean[0]),
        .sck     (clean[1]),
        .sdi     (clean[2]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .sdo     (ser_dout),
        .sdo_oe  (ser_doe),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    ser3w_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_stb),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr   (rd_addr),
        .rdata   (rd_data),
        .filt_en (filt_en)
    );

endmodule

// File: tb/ser3w_slave_tb.sv
module ser3w_slave_tb;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sck = 1'b0;
    logic       din = 1'b0;
    logic       dout, doe, stb;
    logic [6:0] waddr;
    logic [7:0] wdata;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    logic [6:0] last_a = '0;
    logic [7:0] last_d = '0;

    always #4 clk = ~clk;

    ser3w_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ser_en(en), .ser_clk(sck), .ser_din(din),
        .ser_dout(dout), .ser_doe(doe), .wr_stb(stb), .wr_addr(waddr), .wr_data(wdata)
    );

    always @(posedge clk) if (rst_n && stb) begin
        stb_cnt <= stb_cnt + 1;
        last_a  <= waddr;
        last_d  <= wdata;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b; wait_c(H); sck = 1'b1; wait_c(H); sck = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [15:0] f;
        f = {1'b0, a, d};
        en = 1'b1; wait_c(H);
        for (int i = 15; i >= 0; i--) send_bit(f[i]);
        wait_c(H); en = 1'b0; din = 1'b0; wait_c(2*H);
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] v, input string req);
        logic [7:0] h;
        int hdr_oe = 0;
        int dat_noe = 0;
        h = {1'b1, a};
        v = '0;
        en = 1'b1; wait_c(H);
        for (int i = 7; i >= 0; i--) begin
            din = h[i]; wait_c(H);
            if (doe) hdr_oe++;
            sck = 1'b1; wait_c(H); sck = 1'b0;
        end
        din = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_c(H);
            if (!doe) dat_noe++;
            v[i] = dout;
            sck = 1'b1; wait_c(H); sck = 1'b0;
        end
        // R2: turnaround, no drive in header, drive during data
        check(hdr_oe == 0 && dat_noe == 0, "R2 turnaround", hdr_oe + dat_noe, 0);
        wait_c(H);
        // R9: D0 still held after the last falling edge
        check(doe && dout == v[0], "R9 D0 hold", {doe, dout}, {1'b1, v[0]});
        en = 1'b0; wait_c(H);
        check(!doe, "R9 release", doe, 0);
        wait_c(H);
        if (req.len() == 0) v = v;
    endtask

    task automatic expect_reg(input logic [6:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        do_read(a, v, req);
        check(v == e, req, v, e);
    endtask

    function automatic logic [7:0] dflt(input int a);
        case (a)
            16:         return 8'h46;
            17, 20, 23: return 8'hFF;
            18, 19, 21, 22, 24, 25: return 8'h7F;
            default:    return 8'h00;
        endcase
    endfunction

    task automatic t_reset();
        check(!doe && !stb, "R9 reset idle", {doe, stb}, 0);
        expect_reg(7'h00, 8'h28, "R3 id0");
        expect_reg(7'h01, 8'hE0, "R3 id1");
        expect_reg(7'h02, 8'h00, "R3 id2");
        expect_reg(7'h03, 8'h43, "R5 dsr default");
        for (int a = 16; a <= 30; a++) if (a != 29) expect_reg(7'(a), dflt(a), "R4 default");
        expect_reg(7'h05, 8'h00, "R6 reserved read");
        expect_reg(7'h1D, 8'h00, "R6 reserved read");
        expect_reg(7'h25, 8'h00, "R6 out of range read");
    endtask

    task automatic t_write_read();
        int c0;
        c0 = stb_cnt;
        do_write(7'h12, 8'hA5);
        check(stb_cnt == c0 + 1, "R8 one strobe", stb_cnt - c0, 1);
        check(last_a == 7'h12 && last_d == 8'hA5, "R8 strobe payload", {last_a, last_d}, {7'h12, 8'hA5});
        expect_reg(7'h12, 8'hA5, "R1 write 12h");
        do_write(7'h19, 8'h5A);
        expect_reg(7'h19, 8'h5A, "R1 write 19h");
        do_write(7'h1E, 8'h81);
        expect_reg(7'h1E, 8'h81, "R1 write 1Eh");
        do_write(7'h03, 8'h9C);
        expect_reg(7'h03, 8'h9C, "R5 dsr write");
    endtask

    task automatic t_ignored();
        int c0;
        c0 = stb_cnt;
        do_write(7'h00, 8'h55);
        do_write(7'h01, 8'h55);
        do_write(7'h02, 8'h55);
        check(stb_cnt == c0 + 3, "R8 strobe on read-only", stb_cnt - c0, 3);
        expect_reg(7'h00, 8'h28, "R3 id0 after write");
        expect_reg(7'h01, 8'hE0, "R3 id1 after write");
        expect_reg(7'h02, 8'h00, "R3 id2 after write");
        do_write(7'h08, 8'h77);
        do_write(7'h1D, 8'h77);
        do_write(7'h30, 8'h77);
        expect_reg(7'h08, 8'h00, "R6 write 08h ignored");
        expect_reg(7'h1D, 8'h00, "R6 write 1Dh ignored");
        expect_reg(7'h30, 8'h00, "R6 write 30h ignored");
    endtask

    task automatic t_abort();
        logic [15:0] f;
        int c0;
        c0 = stb_cnt;
        f = {1'b0, 7'h1A, 8'hA5};
        en = 1'b1; wait_c(H);
        for (int i = 15; i >= 4; i--) send_bit(f[i]);
        wait_c(H); en = 1'b0; din = 1'b0; wait_c(2*H);
        check(stb_cnt == c0, "R7 no strobe on short frame", stb_cnt - c0, 0);
        expect_reg(7'h1A, 8'h00, "R7 no update on short frame");
    endtask

    task automatic glitch_write(input logic [6:0] a, input logic [7:0] d);
        logic [15:0] f;
        f = {1'b0, a, d};
        en = 1'b1; wait_c(H);
        for (int i = 15; i >= 8; i--) send_bit(f[i]);
        din = 1'b1; wait_c(H);
        sck = 1'b1; wait_c(1); sck = 1'b0; wait_c(H);
        for (int i = 7; i >= 0; i--) send_bit(f[i]);
        wait_c(H); en = 1'b0; din = 1'b0; wait_c(2*H);
    endtask

    task automatic t_deglitch();
        glitch_write(7'h1B, 8'h3C);
        expect_reg(7'h1B, 8'h3C, "R10 glitch filtered");
        do_write(7'h10, 8'h06);
        expect_reg(7'h10, 8'h06, "R10 filter off");
        glitch_write(7'h1B, 8'h3C);
        expect_reg(7'h1B, 8'h9E, "R10 glitch counted");
        do_write(7'h10, 8'h46);
        expect_reg(7'h10, 8'h46, "R10 filter back on");
    endtask

    initial begin
        wait_c(5);
        rst_n = 1'b1;
        wait_c(5);
        t_reset();
        t_write_read();
        t_ignored();
        t_abort();
        t_deglitch();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule